// File: doc/BRIEF.md
# Wavetable Rotation and Debug-Output Controller

This block sits beside a five-channel wavetable tone generator. It owns a single 8-bit mode register and decodes it into three things. The first is a set of per-wave rotation strobes. The second is a counter-restart mode flag and a two-bit rate multiplier, which are passed on to the channel counters. The third is a one-bit debug output, which a selector steers to one of several internal signals. The generator has four 32-entry signed-byte waves. Waves 0, 1 and 2 serve channels 1 to 3. Wave 3 is shared by channels 4 and 5.

The block also holds the four waves and the engine that rotates them. The CPU loads wave entries through a write port, and a combinational read port returns any entry. When a wave's strobe fires, the wave shifts down by one position in a single clock. A rotation that collides with a CPU write to the same wave is held back, so the write always lands.

The rotation source depends on the two high mode bits. With only bit 6 set, waves 0 to 2 follow their own channel ticks and the shared wave follows channel 5. With only bit 7 set, only the shared wave rotates, and it follows channel 4. With both bits set, only waves 0 to 2 rotate. A mode value of zero stops all rotation.

Top module: `wave_rot_ctl`

## Requirements
- R1: After reset the mode register is 0. As a result, `cntResetMode` and `multSel` are 0, no strobe fires for any ticks, `dbgOut` follows `chanTick[0]`, and every wave entry reads 0.
- R2: A value written with `modeWrEn` takes effect from the next clock. `cntResetMode` is mode bit 5 and `multSel` is mode bits 1:0.
- R3: When mode bits 7:6 are 01, `rotStrobe[2:0]` equals `chanTick[2:0]` and `rotStrobe[3]` equals `chanTick[4]` (channel 5).
- R4: When mode bits 7:6 are 10, `rotStrobe[2:0]` is 0 and `rotStrobe[3]` equals `chanTick[3]` (channel 4).
- R5: When mode bits 7:6 are 11, `rotStrobe[2:0]` equals `chanTick[2:0]` and `rotStrobe[3]` is 0.
- R6: When mode bits 7:6 are 00, no strobe fires. Ticks then leave every wave's contents unchanged, including just after the mode is rewritten to 0.
- R7: When mode bits 4:2 hold a value s from 0 to 4, `dbgOut` equals `chanTick[s]`.
- R8: A selector value of 5 drives `sharedIdx[0]` on `dbgOut`, a value of 6 drives `sharedIdx[1]`, and a value of 7 drives 0.
- R9: A strobe seen at a clock edge rotates its wave at that edge. After the edge, entry i holds the old entry (i+1) mod 32.
- R10: A CPU write to a wave in the same cycle as that wave's strobe stores its data at that edge. The rotation is then applied at the following edge.
- R11: A CPU write to one wave does not delay the rotation of another wave in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Load the mode register |
| modeWrData | input | 8 | New mode value |
| chanTick | input | 5 | Frequency-counter ticks of channels 1..5 (bit 0 = channel 1) |
| sharedIdx | input | 2 | Low two address bits of the shared wave |
| cpuWrEn | input | 1 | CPU wave write enable |
| cpuWrWave | input | 2 | Wave written (3 = shared) |
| cpuWrIdx | input | 5 | Entry written |
| cpuWrData | input | 8 | Byte written |
| rdWave | input | 2 | Wave read |
| rdIdx | input | 5 | Entry read |
| rdData | output | 8 | Combinational read data |
| rotStrobe | output | 4 | Rotation strobes for waves 0..3 |
| cntResetMode | output | 1 | Counter-restart mode flag |
| multSel | output | 2 | Rate multiplier select |
| dbgOut | output | 1 | Debug output bit |

## Verification
A wrong decode of the mode register shows up on `rotStrobe` or `dbgOut` in the same cycle as the ticks that reach it. The bench therefore sweeps every tick pattern under every rotation mode and every debug selection. A fault in the rotate engine or in the pending logic leaves wrong bytes in a wave one edge after the strobe. The bench finds it by reading all 128 entries back through the read port and comparing them with its own model of the waves.

// File: rtl/wave_rot_pkg.sv
package wave_rot_pkg;
  localparam int NUM_CH    = 5;
  localparam int NUM_WAVES = 4;
  localparam int WSEL_W    = $clog2(NUM_WAVES);
  localparam int MODE_W    = 8;

  typedef struct packed {
    logic [NUM_WAVES-1:0] rotate;
    logic [NUM_WAVES-1:0] write;
  } rot_ctl_t;
endpackage

// File: rtl/wave_rot_ctrl.sv
module wave_rot_ctrl
  import wave_rot_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          modeWrEn,
  input  logic [MODE_W-1:0]             modeWrData,
  input  logic [NUM_CH-1:0]             chanTick,
  input  logic [1:0]                    sharedIdx,
  input  logic                          cpuWrEn,
  input  logic [WSEL_W-1:0]             cpuWrWave,
  output logic [MODE_W-1:0]             modeQ,
  output logic [NUM_WAVES-1:0]          rotStrobe,
  output logic                          cntResetMode,
  output logic [1:0]                    multSel,
  output logic                          dbgOut,
  output rot_ctl_t                      ctl
);
  localparam int PEND_W = 2;
  localparam int SUM_W  = PEND_W + 1;
  localparam logic [SUM_W-1:0] PEND_MAX = SUM_W'((1 << PEND_W) - 1);

  logic rotLow, rotHigh;
  logic [2:0] dbgSel;

  always_ff @(posedge clk) begin
    if (!rstN)         modeQ <= '0;
    else if (modeWrEn) modeQ <= modeWrData;
  end

  assign rotLow       = modeQ[6];
  assign rotHigh      = modeQ[7];
  assign cntResetMode = modeQ[5];
  assign dbgSel       = modeQ[4:2];
  assign multSel      = modeQ[1:0];

  // Rotation source selection
  always_comb begin
    rotStrobe      = '0;
    rotStrobe[2:0] = rotLow ? chanTick[2:0] : 3'b000;
    rotStrobe[3]   = (rotLow & ~rotHigh & chanTick[4]) |
                     (rotHigh & ~rotLow & chanTick[3]);
  end

  // Debug output selector
  always_comb begin
    case (dbgSel)
      3'd0:    dbgOut = chanTick[0];
      3'd1:    dbgOut = chanTick[1];
      3'd2:    dbgOut = chanTick[2];
      3'd3:    dbgOut = chanTick[3];
      3'd4:    dbgOut = chanTick[4];
      3'd5:    dbgOut = sharedIdx[0];
      3'd6:    dbgOut = sharedIdx[1];
      default: dbgOut = 1'b0;
    endcase
  end

  // Per-wave pending counters: a rotation blocked by a CPU write waits
  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_pend
    logic [PEND_W-1:0] pendCnt;
    logic [SUM_W-1:0]  total;
    logic              wrHit;

    assign wrHit = cpuWrEn && (cpuWrWave == WSEL_W'(w));
    assign total = SUM_W'(pendCnt) + SUM_W'(rotStrobe[w]);

    assign ctl.write[w]  = wrHit;
    assign ctl.rotate[w] = !wrHit && (total != '0);

    always_ff @(posedge clk) begin
      if (!rstN)               pendCnt <= '0;
      else if (ctl.rotate[w])  pendCnt <= PEND_W'(total - SUM_W'(1));
      else if (total > PEND_MAX) pendCnt <= PEND_W'(PEND_MAX);
      else                     pendCnt <= PEND_W'(total);
    end
  end
endmodule

// File: rtl/wave_rot_dp.sv
module wave_rot_dp
  import wave_rot_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WAVE_LEN = 32,
  localparam int IDX_W   = $clog2(WAVE_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rot_ctl_t          ctl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [WSEL_W-1:0] rdWave,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] waveOut [NUM_WAVES];

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
    logic [DATA_W-1:0] mem [WAVE_LEN];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < WAVE_LEN; i++) mem[i] <= '0;
      end else if (ctl.rotate[w]) begin
        for (int i = 0; i < WAVE_LEN; i++) mem[i] <= mem[(i + 1) % WAVE_LEN];
      end else if (ctl.write[w]) begin
        mem[wrIdx] <= wrData;
      end
    end

    assign waveOut[w] = mem[rdIdx];
  end

  assign rdData = waveOut[rdWave];
endmodule

// File: rtl/wave_rot_ctl.sv
module wave_rot_ctl
  import wave_rot_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int WAVE_LEN = 32,
  localparam int IDX_W   = $clog2(WAVE_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [7:0]        modeWrData,
  input  logic [4:0]        chanTick,
  input  logic [1:0]        sharedIdx,
  input  logic              cpuWrEn,
  input  logic [1:0]        cpuWrWave,
  input  logic [IDX_W-1:0]  cpuWrIdx,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [1:0]        rdWave,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        rotStrobe,
  output logic              cntResetMode,
  output logic [1:0]        multSel,
  output logic              dbgOut
);
  rot_ctl_t          ctl;
  logic [MODE_W-1:0] modeQ;

  wave_rot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .chanTick(chanTick), .sharedIdx(sharedIdx),
    .cpuWrEn(cpuWrEn), .cpuWrWave(cpuWrWave),
    .modeQ(modeQ), .rotStrobe(rotStrobe),
    .cntResetMode(cntResetMode), .multSel(multSel),
    .dbgOut(dbgOut), .ctl(ctl)
  );

  wave_rot_dp #(.DATA_W(DATA_W), .WAVE_LEN(WAVE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrIdx(cpuWrIdx), .wrData(cpuWrData),
    .rdWave(rdWave), .rdIdx(rdIdx), .rdData(rdData)
  );
endmodule

// File: rtl/wave_rot_ctl_chk.sv
module wave_rot_ctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] modeQ,
  input logic       modeWrEn,
  input logic [7:0] modeWrData,
  input logic [4:0] chanTick,
  input logic [1:0] sharedIdx,
  input logic [3:0] rotStrobe,
  input logic       cntResetMode,
  input logic [1:0] multSel,
  input logic       dbgOut
);
  p_mode_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn |=> (cntResetMode == $past(modeWrData[5])) && (multSel == $past(modeWrData[1:0])));

  p_rot_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[7:6] == 2'b01) |-> (rotStrobe == {chanTick[4], chanTick[2:0]}));

  p_rot_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[7:6] == 2'b10) |-> (rotStrobe == {chanTick[3], 3'b000}));

  p_rot_both_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[7:6] == 2'b11) |-> (rotStrobe == {1'b0, chanTick[2:0]}));

  p_rot_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[7:6] == 2'b00) |-> (rotStrobe == 4'b0000));

  p_dbg_chan_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[4:2] < 3'd5) |-> (dbgOut == chanTick[modeQ[4:2]]));

  p_dbg_idx_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[4:2] >= 3'd5) |->
      (dbgOut == ((modeQ[4:2] == 3'd5) ? sharedIdx[0] :
                  (modeQ[4:2] == 3'd6) ? sharedIdx[1] : 1'b0)));
endmodule

bind wave_rot_ctl wave_rot_ctl_chk u_chk (
  .clk(clk), .rstN(rstN), .modeQ(modeQ),
  .modeWrEn(modeWrEn), .modeWrData(modeWrData),
  .chanTick(chanTick), .sharedIdx(sharedIdx),
  .rotStrobe(rotStrobe), .cntResetMode(cntResetMode),
  .multSel(multSel), .dbgOut(dbgOut)
);

// File: tb/tb_wave_rot_ctl.sv
`timescale 1ns/1ps
module tb_wave_rot_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWrEn = 1'b0;
  logic [7:0] modeWrData = '0;
  logic [4:0] chanTick = '0;
  logic [1:0] sharedIdx = '0;
  logic       cpuWrEn = 1'b0;
  logic [1:0] cpuWrWave = '0;
  logic [4:0] cpuWrIdx = '0;
  logic [7:0] cpuWrData = '0;
  logic [1:0] rdWave = '0;
  logic [4:0] rdIdx = '0;
  logic [7:0] rdData;
  logic [3:0] rotStrobe;
  logic       cntResetMode;
  logic [1:0] multSel;
  logic       dbgOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  int model [4][32];
  int curMode = 0;

  always #4 clk = ~clk;

  wave_rot_ctl dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .chanTick(chanTick), .sharedIdx(sharedIdx), .cpuWrEn(cpuWrEn),
    .cpuWrWave(cpuWrWave), .cpuWrIdx(cpuWrIdx), .cpuWrData(cpuWrData),
    .rdWave(rdWave), .rdIdx(rdIdx), .rdData(rdData), .rotStrobe(rotStrobe),
    .cntResetMode(cntResetMode), .multSel(multSel), .dbgOut(dbgOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int expStrobe(input int mode, input int t);
    int m = (mode >> 6) & 3;
    int s = 0;
    if (m[0]) s = t & 7;
    if (m == 1) s |= ((t >> 4) & 1) << 3;
    if (m == 2) s |= ((t >> 3) & 1) << 3;
    return s;
  endfunction

  task automatic modelRot(input int w);
    int tmp [32];
    for (int i = 0; i < 32; i++) tmp[i] = model[w][(i + 1) % 32];
    for (int i = 0; i < 32; i++) model[w][i] = tmp[i];
  endtask

  task automatic setMode(input int v);
    @(negedge clk); modeWrEn = 1'b1; modeWrData = 8'(v);
    @(negedge clk); modeWrEn = 1'b0;
    curMode = v;
  endtask

  task automatic cpuWrite(input int w, input int i, input int d);
    @(negedge clk); cpuWrEn = 1'b1; cpuWrWave = 2'(w); cpuWrIdx = 5'(i); cpuWrData = 8'(d);
    @(negedge clk); cpuWrEn = 1'b0;
    model[w][i] = d;
  endtask

  task automatic pulse(input int t);
    int s;
    @(negedge clk); chanTick = 5'(t);
    @(negedge clk); chanTick = '0;
    s = expStrobe(curMode, t);
    for (int w = 0; w < 4; w++) if (s[w]) modelRot(w);
  endtask

  task automatic readAll(input string req);
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 32; i++) begin
        @(negedge clk); rdWave = 2'(w); rdIdx = 5'(i); #1;
        check(int'(rdData) == model[w][i], req, int'(rdData), model[w][i]);
      end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 4; w++) for (int i = 0; i < 32; i++) model[w][i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cntResetMode == 1'b0, "R1 cntResetMode", int'(cntResetMode), 0);
    check(multSel == 2'd0, "R1 multSel", int'(multSel), 0);
    chanTick = 5'b11111; #1;
    check(rotStrobe == 4'd0, "R1 strobes", int'(rotStrobe), 0);
    check(dbgOut == 1'b1, "R1 dbgOut", int'(dbgOut), 1);
    chanTick = 5'b11110; #1;
    check(dbgOut == 1'b0, "R1 dbgOut tick0 low", int'(dbgOut), 0);
    #1 chanTick = '0;
    readAll("R1 waves zero");

    // R2: field positions
    setMode(8'b0010_0011);
    check(cntResetMode == 1'b1, "R2 cntResetMode", int'(cntResetMode), 1);
    check(multSel == 2'd3, "R2 multSel", int'(multSel), 3);
    setMode(8'b0000_0010);
    check(cntResetMode == 1'b0, "R2 cntResetMode clear", int'(cntResetMode), 0);
    check(multSel == 2'd2, "R2 multSel 2", int'(multSel), 2);

    // R3/R4/R5/R6: strobe sweep (ticks removed before the edge)
    for (int m = 0; m < 4; m++) begin
      setMode(m << 6);
      for (int t = 0; t < 32; t++) begin
        @(negedge clk); chanTick = 5'(t); #1;
        check(int'(rotStrobe) == expStrobe(curMode, t),
              (m == 0) ? "R6 strobe" : (m == 1) ? "R3 strobe" : (m == 2) ? "R4 strobe" : "R5 strobe",
              int'(rotStrobe), expStrobe(curMode, t));
        #1 chanTick = '0;
      end
    end

    // R7/R8: debug selector sweep
    for (int s = 0; s < 8; s++) begin
      setMode(s << 2);
      for (int t = 0; t < 32; t++)
        for (int x = 0; x < 4; x++) begin
          int e;
          @(negedge clk); chanTick = 5'(t); sharedIdx = 2'(x); #1;
          e = (s < 5) ? ((t >> s) & 1) : (s == 5) ? (x & 1) : (s == 6) ? ((x >> 1) & 1) : 0;
          check(int'(dbgOut) == e, (s < 5) ? "R7 dbg channel" : "R8 dbg index/low", int'(dbgOut), e);
          #1 chanTick = '0;
        end
    end

    // Load distinct wave contents
    setMode(0);
    for (int w = 0; w < 4; w++) for (int i = 0; i < 32; i++) cpuWrite(w, i, (w << 5) | i);
    readAll("R9 load");

    // R3/R9: bit 6 only
    setMode(8'h40);
    pulse(5'b00001);
    pulse(5'b10000);
    pulse(5'b01000);
    pulse(5'b00110);
    readAll("R3 R9 rotate");
    // R4: bit 7 only
    setMode(8'h80);
    pulse(5'b01000);
    pulse(5'b10111);
    readAll("R4 rotate");
    // R5: both bits
    setMode(8'hC0);
    pulse(5'b11111);
    pulse(5'b00101);
    readAll("R5 rotate");
    // R6: writing 0 stops rotation
    setMode(8'h40);
    setMode(8'h00);
    pulse(5'b11111);
    pulse(5'b11111);
    readAll("R6 frozen");

    // R10: write and strobe on the same wave in one cycle
    setMode(8'h40);
    @(negedge clk);
    chanTick = 5'b00001; cpuWrEn = 1'b1; cpuWrWave = 2'd0; cpuWrIdx = 5'd5; cpuWrData = 8'hA5;
    @(negedge clk);
    chanTick = '0; cpuWrEn = 1'b0;
    model[0][5] = 8'hA5;
    rdWave = 2'd0; rdIdx = 5'd5; #1;
    check(rdData == 8'hA5, "R10 write kept", int'(rdData), 8'hA5);
    rdIdx = 5'd0; #1;
    check(int'(rdData) == model[0][0], "R10 rotation deferred", int'(rdData), model[0][0]);
    modelRot(0);
    @(negedge clk);
    rdIdx = 5'd4; #1;
    check(rdData == 8'hA5, "R10 rotation next edge", int'(rdData), 8'hA5);
    readAll("R10 wave");

    // R11: write to another wave does not delay rotation
    @(negedge clk);
    chanTick = 5'b00001; cpuWrEn = 1'b1; cpuWrWave = 2'd1; cpuWrIdx = 5'd7; cpuWrData = 8'h5A;
    @(negedge clk);
    chanTick = '0; cpuWrEn = 1'b0;
    modelRot(0);
    model[1][7] = 8'h5A;
    rdWave = 2'd0; rdIdx = 5'd0; #1;
    check(int'(rdData) == model[0][0], "R11 immediate rotation", int'(rdData), model[0][0]);
    rdWave = 2'd1; rdIdx = 5'd7; #1;
    check(rdData == 8'h5A, "R11 other write", int'(rdData), 8'h5A);
    readAll("R11 waves");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule